// File: doc/BRIEF.md
# Split-Phase Level-One Data Cache Lookup

This block handles the read lookup of a 16 KB, 4-way set-associative level-one data cache. Its lines are 32 bytes long and it has 128 sets. The low 12 bits of an address fall inside one page, so they are the same before and after translation. The block takes the set index and the word position from those untranslated bits. In the cycle a request is accepted, it reads the tags, valid bits and the addressed word of all four ways of the indexed set into registers. While that read runs, the translation unit works on the upper address bits.

In the following cycle the translation unit presents a 20-bit physical page number. The block compares it with the four registered tags. In that same cycle it reports either a hit with the 32-bit word or a miss with the physical line address for the next level. The next level returns a whole line through the fill port. A fill goes into an empty way if the set has one, and otherwise into the way that a 3-bit tree pseudo-LRU selects.

Top module: `vipt_l1_lookup`

## Requirements
- R1: The request offset `req_voff[11:0]` is split into a set index `req_voff[11:5]` and a word select `req_voff[4:2]`. The 20-bit tag is the physical page number on `xlat_ppn`.
- R2: A request accepted at a rising edge (`req_valid` high) produces `rsp_valid` high for exactly the following cycle. `rsp_valid` is never high at any other time. The page number is sampled in that following cycle.
- R3: `rsp_hit` is high only when a way of the indexed set is valid and holds a tag equal to `xlat_ppn`.
- R4: On a hit, `rsp_word` equals bits [32w+31:32w] of the line that was filled, where w is the word select.
- R5: Offset bits [1:0] have no effect on hit, word or miss address.
- R6: Every response that is not a hit raises `miss_req`, with `miss_line` = {`xlat_ppn`, set index} (27 bits).
- R7: A fill with `fill_valid` high writes the 256-bit line and the tag `fill_line[26:7]` into set `fill_line[6:0]` and marks the way valid. If the set has an invalid way, the lowest-numbered one is used.
- R8: In a full set the fill replaces the pseudo-LRU victim. The state has three bits (b0 root, b1 ways 0/1, b2 ways 2/3). The victim is b0=0 ? (b1 ? way1 : way0) : (b2 ? way3 : way2).
- R9: Each hit and each fill updates the set's state to point away from the touched way. A touch of way 0 or 1 sets b0=1, and a touch of way 2 or 3 sets b0=0. Way 0 sets b1=1, way 1 sets b1=0, way 2 sets b2=1 and way 3 sets b2=0. Reset sets every state to 0.
- R10: A reset (`rst_n` low at a clock edge) clears every valid bit, so every lookup after it misses until a fill.
- R11: `rsp_hit` and `miss_req` are never high together, and neither is high without `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_voff | input | 12 | Untranslated page-offset bits of the request |
| xlat_ppn | input | 20 | Physical page number, valid the cycle after the request |
| rsp_valid | output | 1 | Response cycle |
| rsp_hit | output | 1 | Lookup hit |
| rsp_word | output | 32 | Word read on a hit, zero otherwise |
| miss_req | output | 1 | Request to the next level |
| miss_line | output | 27 | Physical line address of the missing line |
| fill_valid | input | 1 | Line fill strobe |
| fill_line | input | 27 | Physical line address of the fill |
| fill_data | input | 256 | Line contents, byte 0 in bits [7:0] |

## Verification
The bound checker checks the timing rules on every cycle: one response cycle for each request, no response outside it, hit and miss mutually exclusive, the miss address built from the translated page and the earlier index, and silence after reset. Whether a hit is correct, which word is returned, which way a fill replaces, and the effect of the pseudo-LRU order depend on the stored contents. Only the bench's scenarios can show these: a sweep over every set and word, and refill sequences compared against a model of the replacement rules.

// File: rtl/vipt_pkg.sv
// Shared definitions for the split-phase L1 lookup.
// Assumes exactly four ways, organised as a three-bit pseudo-LRU tree.
package vipt_pkg;
    localparam int NWAYS = 4;
    localparam int WAY_W = 2;
    localparam int WORD_W = 32;

    typedef logic [2:0] plru_t;   // [0] root, [1] ways 0/1, [2] ways 2/3

    // Way the tree currently points at for eviction.
    function automatic logic [WAY_W-1:0] plru_pick(input plru_t s);
        if (!s[0]) return s[1] ? 2'd1 : 2'd0;
        return s[2] ? 2'd3 : 2'd2;
    endfunction

    // New tree state after way w was used: point away from w.
    function automatic plru_t plru_touch(input plru_t s, input logic [WAY_W-1:0] w);
        plru_t n = s;
        n[0] = ~w[1];
        if (w[1]) n[2] = ~w[0];
        else      n[1] = ~w[0];
        return n;
    endfunction
endpackage

// File: rtl/vipt_tag_array.sv
// Tag and valid storage for all ways.
// Read is registered on rd_en; the valid row of the fill index is combinational.
// Assumes a fill and a read of the same set never need write-through.
module vipt_tag_array #(
    parameter int SETS  = 128,
    parameter int TAG_W = 20,
    parameter int WAYS  = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int WW    = $clog2(WAYS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_en,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [WAYS-1:0][TAG_W-1:0] rd_tag,
    output logic [WAYS-1:0]            rd_vld,
    input  logic                       wr_en,
    input  logic [WW-1:0]              wr_way,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [TAG_W-1:0]           wr_tag,
    output logic [WAYS-1:0]            row_vld
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [TAG_W-1:0] tag_q [SETS];
        logic [SETS-1:0]  vld_q;

        // Valid bits: cleared by reset, set by a fill into this way.
        always_ff @(posedge clk) begin
            if (!rst_n)                        vld_q <= '0;
            else if (wr_en && wr_way == WW'(w)) vld_q[wr_idx] <= 1'b1;
        end

        // Tag storage written by a fill into this way.
        always_ff @(posedge clk) begin
            if (wr_en && wr_way == WW'(w)) tag_q[wr_idx] <= wr_tag;
        end

        // Registered read of the indexed set for the compare stage.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_vld[w] <= 1'b0;
                rd_tag[w] <= '0;
            end else if (rd_en) begin
                rd_vld[w] <= vld_q[rd_idx];
                rd_tag[w] <= tag_q[rd_idx];
            end
        end

        assign row_vld[w] = vld_q[wr_idx];
    end
endmodule

// File: rtl/vipt_data_array.sv
// Line storage for all ways; returns the selected 32-bit word of each way,
// registered on rd_en. Contents are not reset; the valid bits qualify them.
module vipt_data_array #(
    parameter int SETS   = 128,
    parameter int LINE_W = 256,
    parameter int WAYS   = 4,
    localparam int IDX_W  = $clog2(SETS),
    localparam int WW     = $clog2(WAYS),
    localparam int NWORDS = LINE_W / vipt_pkg::WORD_W,
    localparam int WSEL_W = $clog2(NWORDS)
) (
    input  logic                                 clk,
    input  logic                                 rd_en,
    input  logic [IDX_W-1:0]                     rd_idx,
    input  logic [WSEL_W-1:0]                    rd_wsel,
    output logic [WAYS-1:0][vipt_pkg::WORD_W-1:0] rd_word,
    input  logic                                 wr_en,
    input  logic [WW-1:0]                        wr_way,
    input  logic [IDX_W-1:0]                     wr_idx,
    input  logic [LINE_W-1:0]                    wr_line
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [LINE_W-1:0] line_q [SETS];

        // Whole-line write from the fill port.
        always_ff @(posedge clk) begin
            if (wr_en && wr_way == WW'(w)) line_q[wr_idx] <= wr_line;
        end

        // Registered word read for the compare stage.
        always_ff @(posedge clk) begin
            if (rd_en) rd_word[w] <= line_q[rd_idx][rd_wsel*vipt_pkg::WORD_W +: vipt_pkg::WORD_W];
        end
    end
endmodule

// File: rtl/vipt_plru_table.sv
// Per-set tree pseudo-LRU state. Hit and fill updates may land in the same
// cycle; on the same set the fill update takes effect.
module vipt_plru_table #(
    parameter int SETS = 128,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       hit_en,
    input  logic [IDX_W-1:0]           hit_idx,
    input  logic [vipt_pkg::WAY_W-1:0] hit_way,
    input  logic                       fill_en,
    input  logic [IDX_W-1:0]           fill_idx,
    input  logic [vipt_pkg::WAY_W-1:0] fill_way,
    output logic [vipt_pkg::WAY_W-1:0] victim
);
    import vipt_pkg::*;

    plru_t lru_q [SETS];

    // Reset to all-zero state; touch on hit, then on fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) lru_q[s] <= '0;
        end else begin
            if (hit_en)  lru_q[hit_idx]  <= plru_touch(lru_q[hit_idx], hit_way);
            if (fill_en) lru_q[fill_idx] <= plru_touch(lru_q[fill_idx], fill_way);
        end
    end

    assign victim = plru_pick(lru_q[fill_idx]);
endmodule

// File: rtl/vipt_l1_lookup.sv
// Read lookup of a virtually indexed, physically tagged 4-way L1 data cache.
// Phase 1 (request edge): index and word select from the page offset read the set.
// Phase 2 (next cycle): xlat_ppn is compared with the registered tags; hit/miss
// and the word are driven combinationally. Assumes the page offset is exactly
// index plus line offset, and that fills do not target a set being looked up
// in the same cycle.
module vipt_l1_lookup #(
    parameter int PA_W       = 32,
    parameter int LINE_BYTES = 32,
    parameter int SETS       = 128,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int IDX_W  = $clog2(SETS),
    localparam int PG_W   = OFF_W + IDX_W,
    localparam int TAG_W  = PA_W - PG_W,
    localparam int LA_W   = PA_W - OFF_W,
    localparam int LINE_W = LINE_BYTES * 8,
    localparam int BSEL_W = $clog2(vipt_pkg::WORD_W / 8)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [PG_W-1:0]             req_voff,
    input  logic [TAG_W-1:0]            xlat_ppn,
    output logic                        rsp_valid,
    output logic                        rsp_hit,
    output logic [vipt_pkg::WORD_W-1:0] rsp_word,
    output logic                        miss_req,
    output logic [LA_W-1:0]             miss_line,
    input  logic                        fill_valid,
    input  logic [LA_W-1:0]             fill_line,
    input  logic [LINE_W-1:0]           fill_data
);
    import vipt_pkg::*;

    localparam int WSEL_W = OFF_W - BSEL_W;

    logic [IDX_W-1:0]  req_idx;
    logic [WSEL_W-1:0] req_wsel;
    logic              byte_lane_unused;
    assign req_idx          = req_voff[PG_W-1:OFF_W];
    assign req_wsel         = req_voff[OFF_W-1:BSEL_W];
    assign byte_lane_unused = ^req_voff[BSEL_W-1:0];

    logic             s1_valid;
    logic [IDX_W-1:0] s1_idx;

    // Stage-1 request bookkeeping: the index is held for the compare cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_idx   <= '0;
        end else begin
            s1_valid <= req_valid;
            if (req_valid) s1_idx <= req_idx;
        end
    end

    logic [IDX_W-1:0]  fill_idx;
    logic [TAG_W-1:0]  fill_tag;
    logic [NWAYS-1:0]  fill_row_vld;
    logic [WAY_W-1:0]  plru_victim;
    logic [WAY_W-1:0]  fill_way;
    assign fill_idx = fill_line[IDX_W-1:0];
    assign fill_tag = fill_line[LA_W-1:IDX_W];

    // Fill way: lowest invalid way, else the pseudo-LRU victim.
    always_comb begin
        fill_way = plru_victim;
        for (int w = NWAYS - 1; w >= 0; w--)
            if (!fill_row_vld[w]) fill_way = WAY_W'(w);
    end

    logic [NWAYS-1:0][TAG_W-1:0]  s1_tag;
    logic [NWAYS-1:0]             s1_vld;
    logic [NWAYS-1:0][WORD_W-1:0] s1_word;

    vipt_tag_array #(.SETS(SETS), .TAG_W(TAG_W), .WAYS(NWAYS)) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (req_valid),
        .rd_idx  (req_idx),
        .rd_tag  (s1_tag),
        .rd_vld  (s1_vld),
        .wr_en   (fill_valid),
        .wr_way  (fill_way),
        .wr_idx  (fill_idx),
        .wr_tag  (fill_tag),
        .row_vld (fill_row_vld)
    );

    vipt_data_array #(.SETS(SETS), .LINE_W(LINE_W), .WAYS(NWAYS)) u_data (
        .clk     (clk),
        .rd_en   (req_valid),
        .rd_idx  (req_idx),
        .rd_wsel (req_wsel),
        .rd_word (s1_word),
        .wr_en   (fill_valid),
        .wr_way  (fill_way),
        .wr_idx  (fill_idx),
        .wr_line (fill_data)
    );

    logic [NWAYS-1:0] way_hit;
    logic [WAY_W-1:0] hit_way;
    logic             any_hit;

    // Stage-2 tag compare against the late physical page number.
    always_comb begin
        hit_way  = '0;
        rsp_word = '0;
        for (int w = 0; w < NWAYS; w++) begin
            way_hit[w] = s1_valid && s1_vld[w] && (s1_tag[w] == xlat_ppn);
            if (way_hit[w]) begin
                hit_way  = WAY_W'(w);
                rsp_word = rsp_word | s1_word[w];
            end
        end
        any_hit = |way_hit;
    end

    vipt_plru_table #(.SETS(SETS)) u_plru (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_en   (any_hit),
        .hit_idx  (s1_idx),
        .hit_way  (hit_way),
        .fill_en  (fill_valid),
        .fill_idx (fill_idx),
        .fill_way (fill_way),
        .victim   (plru_victim)
    );

    assign rsp_valid = s1_valid;
    assign rsp_hit   = any_hit;
    assign miss_req  = s1_valid && !any_hit;
    assign miss_line = {xlat_ppn, s1_idx};
endmodule

// File: rtl/vipt_l1_lookup_chk.sv
// Protocol checker for vipt_l1_lookup, attached by bind below.
module vipt_l1_lookup_chk #(
    parameter int IDX_W = 7,
    parameter int TAG_W = 20
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [IDX_W-1:0]   req_idx,
    input logic [TAG_W-1:0]   xlat_ppn,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               miss_req,
    input logic [TAG_W+IDX_W-1:0] miss_line
);
    // R2
    req_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R2
    no_stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R11
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && miss_req));
    // R11
    result_in_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit || miss_req) |-> rsp_valid);
    // R6
    rsp_has_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit || miss_req));
    // R6
    miss_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_req |-> miss_line == {xlat_ppn, $past(req_idx)});
    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !rsp_valid);
endmodule

bind vipt_l1_lookup vipt_l1_lookup_chk #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_idx   (req_voff[PG_W-1:OFF_W]),
    .xlat_ppn  (xlat_ppn),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .miss_req  (miss_req),
    .miss_line (miss_line)
);

// File: tb/vipt_l1_lookup_bench.sv
module vipt_l1_lookup_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [11:0]  req_voff = '0;
    logic [19:0]  xlat_ppn = '0;
    logic         rsp_valid, rsp_hit, miss_req;
    logic [31:0]  rsp_word;
    logic [26:0]  miss_line;
    logic         fill_valid = 1'b0;
    logic [26:0]  fill_line = '0;
    logic [255:0] fill_data = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference state built from the requirement text
    bit       m_vld [128][4];
    bit [19:0] m_tag [128][4];
    bit [2:0] m_lru [128];

    always #5 clk = ~clk;

    vipt_l1_lookup u_vipt_l1_lookup (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_voff(req_voff),
        .xlat_ppn(xlat_ppn), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_word(rsp_word), .miss_req(miss_req), .miss_line(miss_line),
        .fill_valid(fill_valid), .fill_line(fill_line), .fill_data(fill_data)
    );

    function automatic logic [31:0] word_of(input logic [26:0] la, input int w);
        return ({5'd0, la} * 32'h0001_0003) ^ (32'(w) * 32'h1111_0000) ^ 32'h5A5A_00C3;
    endfunction

    function automatic logic [255:0] line_of(input logic [26:0] la);
        logic [255:0] d;
        for (int w = 0; w < 8; w++) d[w*32 +: 32] = word_of(la, w);
        return d;
    endfunction

    // R8 victim and R9 touch rules
    function automatic int m_pick(input bit [2:0] s);
        if (!s[0]) return s[1] ? 1 : 0;
        return s[2] ? 3 : 2;
    endfunction

    function automatic bit [2:0] m_touch(input bit [2:0] s, input int w);
        bit [2:0] n = s;
        n[0] = (w < 2);
        if (w < 2) n[1] = (w == 0);
        else       n[2] = (w == 2);
        return n;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int s = 0; s < 128; s++) begin
            m_lru[s] = '0;
            for (int w = 0; w < 4; w++) m_vld[s][w] = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(rsp_valid == 1'b0 && rsp_hit == 1'b0 && miss_req == 1'b0, "R10 reset outputs",
            {rsp_valid, rsp_hit, miss_req}, 0);
        rst_n = 1'b1;
        model_clear();
    endtask

    // R7: fill one line, mirror the placement in the model
    task automatic do_fill(input logic [19:0] tag, input int idx);
        int way;
        @(negedge clk);
        fill_valid = 1'b1;
        fill_line  = {tag, 7'(idx)};
        fill_data  = line_of({tag, 7'(idx)});
        @(posedge clk);
        #1 fill_valid = 1'b0;
        way = -1;
        for (int w = 3; w >= 0; w--) if (!m_vld[idx][w]) way = w;
        if (way < 0) way = m_pick(m_lru[idx]);
        m_vld[idx][way] = 1'b1;
        m_tag[idx][way] = tag;
        m_lru[idx] = m_touch(m_lru[idx], way);
    endtask

    // One lookup; checks R2, R3, R4, R6 against the model
    task automatic do_lookup(input logic [19:0] tag, input int idx, input int off);
        bit exp_hit;
        int exp_way;
        logic [31:0] exp_word;
        @(negedge clk);
        req_valid = 1'b1;
        req_voff  = {7'(idx), 5'(off)};
        @(posedge clk);
        #1 req_valid = 1'b0;
        xlat_ppn = tag;
        @(negedge clk);
        exp_hit = 1'b0;
        exp_way = 0;
        for (int w = 0; w < 4; w++)
            if (m_vld[idx][w] && m_tag[idx][w] == tag) begin
                exp_hit = 1'b1;
                exp_way = w;
            end
        exp_word = word_of({tag, 7'(idx)}, off / 4);
        chk(rsp_valid == 1'b1, "R2 response cycle", rsp_valid, 1);
        chk(rsp_hit == exp_hit, "R3 hit decision", rsp_hit, exp_hit);
        chk(miss_req == !exp_hit, "R6 miss request", miss_req, !exp_hit);
        if (exp_hit) begin
            chk(rsp_word == exp_word, "R4 R5 word", rsp_word, exp_word);
            m_lru[idx] = m_touch(m_lru[idx], exp_way);
        end else begin
            chk(miss_line == {tag, 7'(idx)}, "R6 miss line", miss_line, {tag, 7'(idx)});
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        model_clear();
        do_reset();

        // R10: nothing hits out of reset
        do_lookup(20'h00000, 9, 0);
        do_lookup(20'hABCDE, 127, 28);

        // R1 R4 R5 R7: one line per set, sweep every word with varied low bits
        for (int s = 0; s < 128; s++) do_fill(20'(s * 7 + 3), s);
        for (int s = 0; s < 128; s++) begin
            for (int w = 0; w < 8; w++) do_lookup(20'(s * 7 + 3), s, w * 4 + (w % 4));
            do_lookup(20'(s * 7 + 4), s, 0);       // R3 wrong tag misses
        end

        // R2: no response without a request
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R2 idle", rsp_valid, 0);

        // R8 R9: fill and refill sets, with hits interleaved
        for (int s = 0; s < 16; s++) begin
            for (int k = 1; k < 4; k++) do_fill(20'h80000 + 20'(s * 16 + k), s);
            do_lookup(20'h80000 + 20'(s * 16 + (s % 3) + 1), s, 8);
            for (int k = 4; k < 9; k++) begin
                do_fill(20'h80000 + 20'(s * 16 + k), s);
                if (k % 2 == 0) do_lookup(20'h80000 + 20'(s * 16 + k - 2), s, 4);
                for (int j = 0; j <= k; j++) do_lookup(20'h80000 + 20'(s * 16 + j), s, 12);
                do_lookup(20'(s * 7 + 3), s, 16);
            end
        end

        // R10: reset in the middle discards all lines
        do_reset();
        for (int s = 0; s < 128; s += 17) do_lookup(20'(s * 7 + 3), s, 0);
        do_fill(20'h12345, 40);
        do_lookup(20'h12345, 40, 20);             // R7 refilled line hits

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule